// File: doc/BRIEF.md
# Power-Down Exit Output Sequencer

This block manages a bank of differential clock output groups while a device comes out of power-down. While the active-high power-down request is held, every output pair sits in its high-impedance state. After the request drops, the pairs are first parked at a driven static level. Once the PLL reports lock, the groups are released to toggle one per clock in a fixed order.

A reference tick measures the time spent in the exit sequence. If the whole bank is not running within a budget of ticks, a sticky timeout flag is raised. One extra selectable output copies the sequencing of either the 96 MHz group or the 100 MHz group, depending on a select input. The PLL, the pads and the voltage levels are modelled here as an input and as state codes.

Top module: `pdexit_seq`

## Requirements
- R1: While `pd_req` is high, every pair in `grp_state` and `sel_state` reads 2'b00 (three-state) in the same cycle, with no clock edge needed. At the first clock edge that samples `pd_req` high, `timeout` clears to 0.
- R2: If `pd_req` rises at any point in the exit sequence, the block drops back to the start. After `pd_req` falls again, the whole sequence repeats from R3.
- R3: At the first clock edge that samples `pd_req` low after power-down, every pair changes from 2'b00 to 2'b01 (driven static level).
- R4: `pll_lock` passes through a two-flop synchroniser. If `pll_lock` is first sampled high at edge k, group 0 reads 2'b10 (running) after edge k+2, and not before.
- R5: Groups are released in ascending index order, one per clock edge. Group i runs after edge k+2+i. All `N_GRP` groups are running within `N_GRP`-1 cycles of group 0.
- R6: A group never runs while a lower-indexed group is not running.
- R7: Once all groups run, they stay at 2'b10 until `pd_req` rises, even if `pll_lock` later drops.
- R8: The block counts `ref_tick` pulses at edges where it is out of power-down and not all groups are running. When that count reaches `BUDGET`, `timeout` goes to 1. It stays at 1 until `pd_req` is sampled high, even after all groups later run.
- R9: `sel_state` equals the group 0 (96 MHz) pair when `sel96` is 1, and the group 1 (100 MHz) pair when `sel96` is 0.
- R10: Each pair uses only the codes 2'b00 (three-state), 2'b01 (driven) and 2'b10 (running). Code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req | input | 1 | Power-down request, active high |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| ref_tick | input | 1 | One-cycle pulse of the free-running reference count |
| sel96 | input | 1 | 1: selectable output follows the 96 MHz group; 0: follows the 100 MHz group |
| grp_state | output | 2*N_GRP | Per-group pair state; group i occupies bits [2i+1:2i] |
| sel_state | output | 2 | State of the selectable 96/100 output |
| timeout | output | 1 | Sticky flag: stable clocks were not reached within BUDGET ticks |

## Verification
The synchroniser assertion assumes that `pll_lock` rises at least one cycle after reset is released and that, once high, it is held across a clock edge. The bench changes `pll_lock` only 1 ns after a rising edge, so every level it drives is held for a full cycle. `pd_req` and `ref_tick` are treated as synchronous inputs, and the bench also changes them only between edges. The one deliberate exception is a mid-cycle rise of `pd_req`, used to show that the outputs go to three-state at once, without waiting for an edge.

// File: rtl/pdexit_seq.sv
module pdexit_seq #(
  parameter int N_GRP  = 4,
  parameter int BUDGET = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_req,
  input  logic               pll_lock,
  input  logic               ref_tick,
  input  logic               sel96,
  output logic [2*N_GRP-1:0] grp_state,
  output logic [1:0]         sel_state,
  output logic               timeout
);
  localparam int RW = $clog2(N_GRP + 1);
  localparam int TW = $clog2(BUDGET + 1);

  typedef enum logic [1:0] {PH_OFF, PH_WAIT, PH_RUN} phase_t;

  phase_t        phase;
  logic [1:0]    sync;
  logic [RW-1:0] run_cnt;
  logic [TW-1:0] tick_cnt;
  logic          lock_s, all_run, counting, quiet;

  assign lock_s   = sync[1];
  assign all_run  = (run_cnt == RW'(N_GRP));
  assign counting = !pd_req && (phase != PH_OFF) && !all_run && ref_tick;
  assign quiet    = pd_req || (phase == PH_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], pll_lock};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pd_req) begin
      phase    <= PH_OFF;
      run_cnt  <= '0;
      tick_cnt <= '0;
      timeout  <= 1'b0;
    end else begin
      case (phase)
        PH_OFF:  phase <= PH_WAIT;
        PH_WAIT: if (lock_s) begin
                   phase   <= PH_RUN;
                   run_cnt <= RW'(1);
                 end
        default: if (!all_run) run_cnt <= run_cnt + RW'(1);
      endcase
      if (counting) begin
        if (tick_cnt != TW'(BUDGET)) tick_cnt <= tick_cnt + TW'(1);
        if (tick_cnt >= TW'(BUDGET - 1)) timeout <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_GRP; i++) begin : g_grp
    assign grp_state[2*i +: 2] = quiet ? 2'b00 :
                                 ((phase == PH_RUN) && (run_cnt > RW'(i))) ? 2'b10 : 2'b01;

    a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      grp_state[2*i +: 2] != 2'b11);

    if (i > 0) begin : g_ord
      a_r6_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_state[2*i +: 2] == 2'b10) |-> (grp_state[2*i-2 +: 2] == 2'b10));
    end
  end

  assign sel_state = sel96 ? grp_state[1:0] : grp_state[3:2];

  a_r3_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!pd_req) && !pd_req) |-> (grp_state[1:0] != 2'b00));

  a_r4_lock_synced: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_state[1:0] == 2'b10) |-> $past(pll_lock, 3));

  a_r7_hold_running: assert property (@(posedge clk) disable iff (!rst_n)
    (all_run && phase == PH_RUN && !pd_req) |=> (grp_state[2*N_GRP-1 -: 2] == 2'b10 || pd_req));

  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !pd_req) |=> timeout);

  a_r1_timeout_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> !timeout);
endmodule

// File: tb/pdexit_seq_bench.sv
module pdexit_seq_bench;
  localparam int N = 4;
  localparam int B = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pd_req = 1'b1, pll_lock = 1'b0, ref_tick = 1'b0, sel96 = 1'b0;
  logic [2*N-1:0] grp_state;
  logic [1:0] sel_state;
  logic timeout;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  string tag = "R1";

  int m_ph = 0, m_run = 0, m_tick = 0, m_to = 0, m_s1 = 0, m_s2 = 0;
  int tick_per = 0, tick_cnt = 0;

  always #4 clk = ~clk;

  pdexit_seq #(.N_GRP(N), .BUDGET(B)) u_pdexit_seq (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pll_lock(pll_lock),
    .ref_tick(ref_tick), .sel96(sel96), .grp_state(grp_state),
    .sel_state(sel_state), .timeout(timeout));

  function automatic logic [1:0] exp_grp(int i);
    if (pd_req || m_ph == 0) return 2'b00;
    if (m_ph == 2 && i < m_run) return 2'b10;
    return 2'b01;
  endfunction

  task automatic check(string t, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [2*N-1:0] eg;
    for (int i = 0; i < N; i++) eg[2*i +: 2] = exp_grp(i);
    check(tag, grp_state, eg, "grp_state");
    check(sel96 ? "R9 (96)" : "R9 (100)", sel_state, sel96 ? eg[1:0] : eg[3:2], "sel_state");
    check(tag, timeout, m_to, "timeout");
  endtask

  task automatic model_edge();
    int s1n, was_run;
    s1n = pll_lock;
    was_run = m_run;
    if (!rst_n || pd_req) begin
      m_ph = 0; m_run = 0; m_tick = 0; m_to = 0;
    end else begin
      if (m_ph != 0 && was_run < N && ref_tick) begin
        if (m_tick < B) m_tick++;
        if (m_tick >= B) m_to = 1;
      end
      if (m_ph == 0) m_ph = 1;
      else if (m_ph == 1) begin
        if (m_s2 != 0) begin m_ph = 2; m_run = 1; end
      end else if (m_run < N) m_run++;
    end
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    else begin m_s2 = m_s1; m_s1 = s1n; end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      #1;
      compare();
      tick_cnt++;
      ref_tick = (tick_per > 0) && (tick_cnt % tick_per == 0);
    end
  endtask

  initial begin : watchdog
    while (cycles < 5000 && !done) @(posedge clk) cycles++;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset and held power-down
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R3 R4 R5: release, lock later, staggered enable
    tag = "R3"; tick_per = 4;
    pd_req = 1'b0;
    cyc(1);
    check("R3", grp_state, {N{2'b01}}, "all driven after first edge");
    cyc(4);
    tag = "R4"; pll_lock = 1'b1;
    cyc(2);
    check("R4", grp_state[1:0], 2'b01, "group 0 still driven two edges after lock");
    tag = "R5";
    cyc(1);
    check("R5", grp_state[1:0], 2'b10, "group 0 running at third edge");
    check("R5", grp_state[3:2], 2'b01, "group 1 not yet running");
    cyc(N - 1);
    check("R5", grp_state, {N{2'b10}}, "all running after N-1 more edges");

    // R7: hold running despite lock loss; R9 toggles
    tag = "R7"; pll_lock = 1'b0;
    cyc(3);
    sel96 = 1'b1;
    cyc(2);
    check("R7", grp_state, {N{2'b10}}, "still running after lock drop");

    // R2: reassert mid-enable, immediate three-state
    tag = "R2"; pd_req = 1'b1; sel96 = 1'b0;
    cyc(2);
    pd_req = 1'b0; pll_lock = 1'b1;
    cyc(5);
    pd_req = 1'b1;
    #1;
    check("R1", grp_state, 0, "three-state without edge");
    check("R1", sel_state, 0, "selectable three-state without edge");
    cyc(2);
    pd_req = 1'b0;
    cyc(1);
    check("R2", grp_state, {N{2'b01}}, "restart drives all pairs");
    cyc(2 + N);
    check("R2", grp_state, {N{2'b10}}, "restart completes");

    // R6 R9: one-cycle lock pulse, sel96 alternating during enable
    tag = "R6"; pd_req = 1'b1; pll_lock = 1'b0;
    cyc(2);
    pd_req = 1'b0;
    cyc(3);
    pll_lock = 1'b1;
    cyc(1);
    pll_lock = 1'b0;
    for (int k = 0; k < N + 3; k++) begin sel96 = ~sel96; cyc(1); end
    check("R6", grp_state, {N{2'b10}}, "single lock pulse completes enable");

    // R8: timeout without lock, then sticky, then cleared
    tag = "R8"; pd_req = 1'b1; tick_per = 1;
    cyc(2);
    pd_req = 1'b0;
    cyc(B - 1);
    check("R8", timeout, 0, "no timeout before budget");
    cyc(3);
    check("R8", timeout, 1, "timeout after budget");
    pll_lock = 1'b1;
    cyc(N + 4);
    check("R8", timeout, 1, "timeout sticky after running");
    check("R10", grp_state, {N{2'b10}}, "only legal codes reached");
    tag = "R1"; pd_req = 1'b1; pll_lock = 1'b0;
    cyc(1);
    check("R1", timeout, 0, "timeout cleared by power-down");
    cyc(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule